// File: doc/BRIEF.md
# Interrupt Flag Controller

This block holds the interrupt control register of a small 8-bit microcontroller and decides when the core must wake up or branch to the interrupt vector. It gathers events from three sources. The first is an external pin, whose active edge can be selected. The second is a comparison between the upper nibble of an 8-bit port and a copy of that nibble taken at the last port read. The third is an overflow strobe from an 8-bit timer. Each event sets a sticky flag in the register. Software clears a flag by writing the register.

The block contains its own four-phase counter (Q1 to Q4), and four clocks make one instruction cycle. Enabled flags are sampled once per instruction cycle, during Q1. When the sampled request is present, the global enable is 1 and the core is running, a short sequencer takes the interrupt at the end of the cycle. The sequencer clears the global enable, marks one dummy instruction cycle, and then marks the vector-fetch cycle with the vector address. While the core sleeps, the block raises a wake request instead. The wake request depends only on the individual enables.

All pins are plain levels or one-clock strobes, with no handshake. The core pulses the port-read strobe in the clock of a port read. The port nibble and the timer strobe are synchronous to the clock. The external pin may be asynchronous.

Top module: `irqc_top`

## Requirements
- R1: While reset is held, the register reads 0x00, wake_req_o, vec_req_o, dummy_cyc_o and vec_fetch_o are 0, and phase_o is 0 (Q1). After reset, phase_o steps 0,1,2,3 and wraps, one step per clock.
- R2: The external flag is register bit 1. With edge_rise_i=1 a low-to-high change of ext_pin_i sets it and a high-to-low change does not. With edge_rise_i=0 the reverse holds.
- R3: A tmr_ovf_i strobe sets the timer flag, register bit 2, in the clock edge that samples it.
- R4: The port-change flag is register bit 0. It is set in any clock where port_hi_i differs from the nibble captured at the last port_rd_i strobe (0 after reset) and port_rd_i is low.
- R5: In a clock with port_rd_i high, the snapshot takes the current port_hi_i and the port-change flag is not set. A change that arrives in that same clock is therefore lost.
- R6: Flags are never cleared by hardware. A write loads bit 7 (global enable), bit 5 (timer enable), bit 4 (external enable), bit 3 (port enable) and the flag bits 2..0 from reg_wdata_i. Bit 6 always reads 0. A hardware set in the same clock as a write of 0 leaves the flag at 1.
- R7: wake_req_o is 1 exactly when sleeping_i is 1 and some flag has its enable set. The global enable has no effect on it.
- R8: vec_req_o is 1 when the core is awake, the global enable is 1, and an enabled flag was present in the most recent Q1 clock.
- R9: When vec_req_o is 1 at the Q4 clock, the global enable is cleared at that edge. The next instruction cycle has dummy_cyc_o=1, and the cycle after it has vec_fetch_o=1 with vec_addr_o=0x0004. A timer strobe in instruction cycle m gives the vector fetch in cycle m+3.
- R10: The external flag is set only at edges that close a Q4 or Q1 clock. A pin change in cycle m gives the vector fetch in cycle m+3 or m+4.
- R11: A flag whose enable is 0 produces neither wake_req_o nor vec_req_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock, one clock per phase |
| rst_ni | input | 1 | Active-low reset |
| ext_pin_i | input | 1 | External interrupt pin, asynchronous |
| edge_rise_i | input | 1 | 1 selects the rising edge, 0 selects the falling edge |
| port_hi_i | input | PORT_W | Upper nibble of the port |
| port_rd_i | input | 1 | Port-read strobe from the core |
| tmr_ovf_i | input | 1 | Timer overflow strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register contents |
| sleeping_i | input | 1 | Core is in sleep |
| phase_o | output | 2 | Current phase, 0..3 for Q1..Q4 |
| wake_req_o | output | 1 | Wake request to the sleeping core |
| vec_req_o | output | 1 | Sampled interrupt request |
| dummy_cyc_o | output | 1 | Dummy instruction cycle of the interrupt entry |
| vec_fetch_o | output | 1 | Vector-fetch instruction cycle |
| vec_addr_o | output | VEC_AW | Vector address during the fetch, else 0 |

## Verification
The two hardest situations are the lost port change and the latency to the vector, because both depend on the exact clock inside the instruction cycle. The bench watches phase_o. It changes the port nibble in the same clock as the read strobe to produce the lost change. It applies the timer strobe and the external pin change once in each of the four phases, and for every round it counts the Q1 phases seen before vec_fetch_o rises. For the external pin, the synchronizer and the Q4/Q1 window make the count phase-dependent, so the expected count is a range of 3 to 4 rather than a single value.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [1:0] {
    PH_Q1 = 2'd0,
    PH_Q2 = 2'd1,
    PH_Q3 = 2'd2,
    PH_Q4 = 2'd3
  } phase_t;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_DUMMY = 2'd1,
    SQ_FETCH = 2'd2
  } seq_t;

  // Control register layout
  localparam int unsigned REG_W     = 8;
  localparam int unsigned B_PCHG_F  = 0;
  localparam int unsigned B_EXT_F   = 1;
  localparam int unsigned B_TMR_F   = 2;
  localparam int unsigned B_PCHG_E  = 3;
  localparam int unsigned B_EXT_E   = 4;
  localparam int unsigned B_TMR_E   = 5;
  localparam int unsigned B_SPARE   = 6;
  localparam int unsigned B_GLB_E   = 7;

endpackage

// File: rtl/irqc_phase_gen.sv
module irqc_phase_gen
  import irqc_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  output phase_t phase_o
);

  logic [1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= 2'd0;
    else         cnt_q <= cnt_q + 2'd1;
  end

  assign phase_o = phase_t'(cnt_q);

  AST_PHASE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == PH_Q4) |=> (phase_o == PH_Q1)); // R1

endmodule

// File: rtl/irqc_ext_edge.sv
module irqc_ext_edge
  import irqc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   pin_i,
  input  logic   rise_sel_i,
  input  phase_t phase_i,
  output logic   set_o
);

  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   lvl_q;
  logic                   pend_q;
  logic                   evt;
  logic                   window;

  if (SYNC_STAGES > 1) begin : g_chain
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q <= '0;
      else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
    end
  end else begin : g_single
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q <= '0;
      else         sync_q <= pin_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= sync_q[LAST];
  end

  assign evt    = rise_sel_i ? (sync_q[LAST] & ~lvl_q) : (~sync_q[LAST] & lvl_q);
  assign window = (phase_i == PH_Q4) || (phase_i == PH_Q1);

  // Hold an edge seen outside the Q4/Q1 window until the window opens.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= 1'b0;
    else if (window) pend_q <= 1'b0;
    else if (evt)    pend_q <= 1'b1;
  end

  assign set_o = window & (pend_q | evt);

endmodule

// File: rtl/irqc_port_change.sv
module irqc_port_change #(
  parameter int unsigned PORT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PORT_W-1:0] port_i,
  input  logic              rd_i,
  output logic              set_o
);

  logic [PORT_W-1:0] snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   snap_q <= '0;
    else if (rd_i) snap_q <= port_i;
  end

  // A read in the same clock as a change reloads the copy and hides the change.
  assign set_o = (port_i != snap_q) & ~rd_i;

endmodule

// File: rtl/irqc_vector_seq.sv
module irqc_vector_seq
  import irqc_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  phase_t phase_i,
  input  logic   req_i,
  output logic   take_o,
  output logic   dummy_o,
  output logic   fetch_o
);

  seq_t state_q;
  logic cyc_end;

  assign cyc_end = (phase_i == PH_Q4);
  assign take_o  = (state_q == SQ_IDLE) && req_i && cyc_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
    end else if (cyc_end) begin
      case (state_q)
        SQ_IDLE:  if (req_i) state_q <= SQ_DUMMY;
        SQ_DUMMY: state_q <= SQ_FETCH;
        default:  state_q <= SQ_IDLE;
      endcase
    end
  end

  assign dummy_o = (state_q == SQ_DUMMY);
  assign fetch_o = (state_q == SQ_FETCH);

  AST_FETCH_FOLLOWS_DUMMY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dummy_o) |-> fetch_o); // R9
  AST_FETCH_STARTS_Q1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fetch_o) |-> (phase_i == PH_Q1)); // R9

endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int unsigned PORT_W      = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned VEC_AW      = 13,
  parameter int unsigned VEC_ADDR    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_pin_i,
  input  logic              edge_rise_i,
  input  logic [PORT_W-1:0] port_hi_i,
  input  logic              port_rd_i,
  input  logic              tmr_ovf_i,
  input  logic              reg_wr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              sleeping_i,
  output logic [1:0]        phase_o,
  output logic              wake_req_o,
  output logic              vec_req_o,
  output logic              dummy_cyc_o,
  output logic              vec_fetch_o,
  output logic [VEC_AW-1:0] vec_addr_o
);

  localparam logic [VEC_AW-1:0] VEC_VAL = VEC_AW'(VEC_ADDR);

  phase_t phase;
  logic   ext_set, pchg_set, take;
  logic   f_pchg_q, f_ext_q, f_tmr_q;
  logic   e_pchg_q, e_ext_q, e_tmr_q;
  logic   glb_q, smp_q;
  logic   any_en;
  logic   spare_unused;

  assign spare_unused = reg_wdata_i[B_SPARE];

  irqc_phase_gen u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_o (phase)
  );

  irqc_ext_edge #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (ext_pin_i),
    .rise_sel_i (edge_rise_i),
    .phase_i    (phase),
    .set_o      (ext_set)
  );

  irqc_port_change #(.PORT_W(PORT_W)) u_pchg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .port_i (port_hi_i),
    .rd_i   (port_rd_i),
    .set_o  (pchg_set)
  );

  // Flags: a write loads them, a hardware event sets them, nothing else clears.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f_pchg_q <= 1'b0;
      f_ext_q  <= 1'b0;
      f_tmr_q  <= 1'b0;
    end else begin
      f_pchg_q <= (reg_wr_i ? reg_wdata_i[B_PCHG_F] : f_pchg_q) | pchg_set;
      f_ext_q  <= (reg_wr_i ? reg_wdata_i[B_EXT_F]  : f_ext_q)  | ext_set;
      f_tmr_q  <= (reg_wr_i ? reg_wdata_i[B_TMR_F]  : f_tmr_q)  | tmr_ovf_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      e_pchg_q <= 1'b0;
      e_ext_q  <= 1'b0;
      e_tmr_q  <= 1'b0;
    end else if (reg_wr_i) begin
      e_pchg_q <= reg_wdata_i[B_PCHG_E];
      e_ext_q  <= reg_wdata_i[B_EXT_E];
      e_tmr_q  <= reg_wdata_i[B_TMR_E];
    end
  end

  // Taking the interrupt outranks a software write of the global enable.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       glb_q <= 1'b0;
    else if (take)     glb_q <= 1'b0;
    else if (reg_wr_i) glb_q <= reg_wdata_i[B_GLB_E];
  end

  assign any_en = (f_pchg_q & e_pchg_q) | (f_ext_q & e_ext_q) | (f_tmr_q & e_tmr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              smp_q <= 1'b0;
    else if (phase == PH_Q1)  smp_q <= any_en;
  end

  assign wake_req_o = sleeping_i & any_en;
  assign vec_req_o  = ~sleeping_i & glb_q & smp_q;

  irqc_vector_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_i (phase),
    .req_i   (vec_req_o),
    .take_o  (take),
    .dummy_o (dummy_cyc_o),
    .fetch_o (vec_fetch_o)
  );

  always_comb begin
    reg_rdata_o           = '0;
    reg_rdata_o[B_GLB_E]  = glb_q;
    reg_rdata_o[B_TMR_E]  = e_tmr_q;
    reg_rdata_o[B_EXT_E]  = e_ext_q;
    reg_rdata_o[B_PCHG_E] = e_pchg_q;
    reg_rdata_o[B_TMR_F]  = f_tmr_q;
    reg_rdata_o[B_EXT_F]  = f_ext_q;
    reg_rdata_o[B_PCHG_F] = f_pchg_q;
  end

  assign phase_o    = phase;
  assign vec_addr_o = vec_fetch_o ? VEC_VAL : '0;

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(f_tmr_q) && !$past(reg_wr_i)) |-> f_tmr_q); // R6
  AST_EXT_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(f_ext_q) && !$past(reg_wr_i)) |->
      ($past(phase) == PH_Q4 || $past(phase) == PH_Q1)); // R10
  AST_READ_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(port_rd_i) && !$past(reg_wr_i) && !$past(f_pchg_q)) |-> !f_pchg_q); // R5
  AST_WAKE_ONLY_ASLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_req_o |-> sleeping_i); // R7
  AST_VEC_NEEDS_GLB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_req_o |-> reg_rdata_o[B_GLB_E]); // R8

endmodule

// File: tb/irqc_top_tb_top.sv
module irqc_top_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_pin = 1'b0, edge_rise = 1'b1;
  logic [3:0] port_hi = 4'd0;
  logic       port_rd = 1'b0, tmr_ovf = 1'b0, reg_wr = 1'b0, sleeping = 1'b0;
  logic [7:0] wdata = 8'd0, rdata;
  logic [1:0] phase;
  logic       wake_req, vec_req, dummy_cyc, vec_fetch;
  logic [12:0] vec_addr;

  always #4 clk = ~clk;

  irqc_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ext_pin_i(ext_pin), .edge_rise_i(edge_rise),
    .port_hi_i(port_hi), .port_rd_i(port_rd), .tmr_ovf_i(tmr_ovf),
    .reg_wr_i(reg_wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .sleeping_i(sleeping), .phase_o(phase), .wake_req_o(wake_req),
    .vec_req_o(vec_req), .dummy_cyc_o(dummy_cyc), .vec_fetch_o(vec_fetch),
    .vec_addr_o(vec_addr)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;
  bit mon_busy = 1'b0;

  typedef struct { string req; int lo; int hi; } exp_t;
  exp_t sbq[$];

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_rng(string req, string what, int act, int lo, int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic nclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic wait_ph(int p);
    @(negedge clk);
    while (int'(phase) != p) @(negedge clk);
  endtask

  // Monitor: pops one expected entry per vector fetch
  initial begin
    int cnt;
    int dcnt;
    bit vseen;
    exp_t it;
    forever begin
      @(negedge clk); #1;
      if (!mon_busy) begin
        if (sbq.size() > 0) begin
          mon_busy = 1'b1; cnt = 0; dcnt = -1; vseen = 1'b0;
        end
      end else begin
        if (phase == 2'd0) cnt++;
        if (vec_req) vseen = 1'b1;
        if (dummy_cyc && dcnt < 0) dcnt = cnt;
        if (vec_fetch) begin
          it = sbq.pop_front();
          chk_rng(it.req, "instruction cycles to vector fetch", cnt, it.lo, it.hi);
          chk("R9", "dummy cycle just before fetch", dcnt, cnt - 1);
          chk("R9", "vector address", int'(vec_addr), 4);
          chk("R9", "global enable cleared on entry", int'(rdata[7]), 0);
          chk("R8", "vec_req seen before entry", int'(vseen), 1);
          mon_busy = 1'b0;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    nclk(3);
    // R1 reset state
    chk("R1", "register in reset", int'(rdata), 0);
    chk("R1", "phase in reset", int'(phase), 0);
    chk("R1", "outputs in reset", int'({wake_req, vec_req, dummy_cyc, vec_fetch}), 0);
    rst_n = 1'b1;
    wait_ph(0); @(negedge clk);
    chk("R1", "phase steps after reset", int'(phase), 1);

    // R3 timer strobe, R11 disabled source gives nothing
    sleeping = 1'b1;
    tmr_ovf = 1'b1; @(negedge clk); tmr_ovf = 1'b0;
    chk("R3", "timer flag set", int'(rdata[2]), 1);
    nclk(6);
    chk("R11", "wake with enable 0", int'(wake_req), 0);
    sleeping = 1'b0; nclk(1);
    chk("R11", "vec_req with enable 0", int'(vec_req), 0);

    // R6 sticky flags and write behaviour
    chk("R6", "flag stays set", int'(rdata[2]), 1);
    wr(8'h00);
    chk("R6", "write clears flag", int'(rdata), 0);
    wr(8'hFF);
    chk("R6", "write all ones, bit 6 reads 0", int'(rdata), 'hBF);
    wr(8'h00);
    @(negedge clk); reg_wr = 1'b1; wdata = 8'h00; tmr_ovf = 1'b1;
    @(negedge clk); reg_wr = 1'b0; tmr_ovf = 1'b0;
    chk("R6", "hardware set beats write of 0", int'(rdata[2]), 1);
    wr(8'h00);

    // R2 edge polarity
    edge_rise = 1'b1; ext_pin = 1'b1; nclk(12);
    chk("R2", "rising edge with rise select", int'(rdata[1]), 1);
    wr(8'h00);
    ext_pin = 1'b0; nclk(12);
    chk("R2", "falling edge ignored with rise select", int'(rdata[1]), 0);
    edge_rise = 1'b0; nclk(2);
    ext_pin = 1'b1; nclk(12);
    chk("R2", "rising edge ignored with fall select", int'(rdata[1]), 0);
    ext_pin = 1'b0; nclk(12);
    chk("R2", "falling edge with fall select", int'(rdata[1]), 1);
    wr(8'h00);

    // R4 port change against snapshot
    @(negedge clk); port_hi = 4'b0101;
    @(negedge clk);
    chk("R4", "mismatch sets port flag", int'(rdata[0]), 1);
    port_rd = 1'b1; @(negedge clk); port_rd = 1'b0;
    wr(8'h00); nclk(3);
    chk("R4", "no flag after read matched", int'(rdata[0]), 0);

    // R5 change in the read clock is lost
    @(negedge clk); port_hi = 4'b1100; port_rd = 1'b1;
    @(negedge clk); port_rd = 1'b0;
    nclk(3);
    chk("R5", "change during read lost", int'(rdata[0]), 0);
    port_hi = 4'b0000; @(negedge clk);
    chk("R5", "later change detected", int'(rdata[0]), 1);
    port_rd = 1'b1; @(negedge clk); port_rd = 1'b0;
    wr(8'h00);

    // R7 wake gated only by individual enable
    edge_rise = 1'b1;
    wr(8'h10);
    sleeping = 1'b1; ext_pin = 1'b1; nclk(12);
    chk("R7", "wake with global enable 0", int'(wake_req), 1);
    chk("R8", "no vec_req while asleep", int'(vec_req), 0);
    sleeping = 1'b0; nclk(6);
    chk("R7", "wake drops when awake", int'(wake_req), 0);
    chk("R8", "no vec_req with global enable 0", int'(vec_req), 0);
    wr(8'h00);

    // R9 timer latency in each phase
    for (int p = 0; p < 4; p++) begin
      wr(8'h20); nclk(6);
      wr(8'hA0); nclk(6);
      chk("R8", "no vec_req without a flag", int'(vec_req), 0);
      wait_ph(p);
      tmr_ovf = 1'b1;
      sbq.push_back('{"R9", 3, 3});
      @(negedge clk); tmr_ovf = 1'b0;
      wait (sbq.size() == 0 && !mon_busy);
      nclk(2);
    end

    // R10 external latency in each phase, alternating polarity
    for (int p = 0; p < 4; p++) begin
      logic nv;
      nv = ~ext_pin;
      wr(8'h10); nclk(6);
      edge_rise = nv;
      wr(8'h90); nclk(6);
      wait_ph(p);
      ext_pin = nv;
      sbq.push_back('{"R10", 3, 4});
      @(negedge clk);
      wait (sbq.size() == 0 && !mon_busy);
      nclk(2);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule